// File: doc/BRIEF.md
# Extension Interface Handle Translator

This block turns a portable extension-interface identifier into a short hardware handle. A request carries a source word and a data word. The source word holds an interface identifier and a device sequence number. The request also carries the current privilege level and a variant select. The block compares the identifier and device number against every entry of a small associative table in parallel. An entry only counts when it is enabled for the current privilege level. The result is a single packed word: the 12-bit handle in the low bits, with the low part of the data word above it.

When nothing matches, the result is a small fallback handle chosen by the variant. That handle later selects a trapping, return-zero or return-minus-one command target. Two mandatory fallback interfaces are built in. They are always found, at every privilege level, and no table load is needed for them. Device number zero asks for the default implementation of an interface.

The translation keeps no state between requests. The table is written only through a configuration port, at boot time. Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake. The output holds one result. A new request is accepted only when that slot is empty or is being drained in the same cycle, so downstream back-pressure stalls the request side.

Top module: `xlt_translator`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` is low and `req_ready` is high. A request that matches no built-in interface then misses.
- R2: In `req_src`, bits 11:0 are the device sequence number and bits XLEN-1:12 are the interface identifier. A table entry hits only when both fields are equal to its stored fields.
- R3: On a hit, `rsp_data` bits 11:0 are the entry's handle and bits XLEN-1:12 are `req_data` bits XLEN-13:0. The top 12 bits of `req_data` are dropped.
- R4: On a miss, `rsp_data` is the variant's fallback value with every other bit zero. `req_variant` 0 (trap) gives 0, 1 (return zero) gives 1, 2 (return minus one) gives 2, and the reserved value 3 gives 0.
- R5: `req_priv` is one-hot: user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100, machine 4'b1000. Each entry holds a 4-bit mask in the same bit order and hits only when the bit for the current level is set. A `req_priv` that is not one-hot always misses, including for the built-in interfaces.
- R6: Identifier 1 with device 0 always yields handle 1, and identifier 2 with device 0 always yields handle 2, at every valid privilege level. These built-in answers take precedence over any table entry with the same key.
- R7: When several table entries hit, the handle comes from the lowest-indexed one.
- R8: When `cfg_we` is high at a clock edge, the entry at `cfg_idx` is overwritten with `cfg_valid`, identifier, device, mask and handle. Writing `cfg_valid` = 0 removes the entry. A write affects requests accepted at later edges, but not a request accepted at the same edge.
- R9: A request is accepted at an edge where `req_valid` and `req_ready` are both high. Its result appears on `rsp_data` with `rsp_valid` high right after that edge. `rsp_valid` never rises without an accepted request.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` holds its value. When `rsp_ready` is high, a new request is accepted in the same cycle the old result drains.
- R11: Lookups change no state: the same request repeated with no table write in between gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears table and output |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 4 | Entry index to write |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_ident | input | XLEN-12 | Interface identifier written |
| cfg_dev | input | 12 | Device sequence number written |
| cfg_priv | input | 4 | Privilege mask written (bit0 user .. bit3 machine) |
| cfg_handle | input | 12 | Handle written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_src | input | XLEN | Identifier (high) and device number (low 12) |
| req_data | input | XLEN | Data word packed above the handle |
| req_priv | input | 4 | Current privilege level, one-hot |
| req_variant | input | 2 | Miss behaviour: 0 trap, 1 zero, 2 minus one |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_data | output | XLEN | Packed handle and data, or fallback value |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request. The bench drives inputs on the falling edge and reads `rsp_valid` and `rsp_data` on the next falling edge, after a single rising edge has passed. For stalls, the bench holds `rsp_ready` low and samples on several falling edges in a row. It checks that the old result stays put and that the waiting request is taken only on the edge where the output drains. Table writes are modelled as taking effect at the write edge. A request issued in the same cycle as a write is therefore predicted from the table as it was before the write.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PRIV_W = 4;

  localparam logic [PRIV_W-1:0] PRIV_USER  = 4'b0001;
  localparam logic [PRIV_W-1:0] PRIV_SUPER = 4'b0010;
  localparam logic [PRIV_W-1:0] PRIV_HYPER = 4'b0100;
  localparam logic [PRIV_W-1:0] PRIV_MACH  = 4'b1000;

  typedef enum logic [1:0] {
    VAR_TRAP = 2'd0,
    VAR_ZERO = 2'd1,
    VAR_MONE = 2'd2,
    VAR_RSVD = 2'd3
  } variant_e;

  // built-in interfaces: identifier k (device 0) maps to handle k
  localparam int NUM_BUILTIN = 2;

  function automatic logic is_onehot4(input logic [PRIV_W-1:0] p);
    return (p != '0) && ((p & (p - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/xlt_table.sv
module xlt_table #(
  parameter int ENTRIES = 16,
  parameter int ID_W    = 20,
  parameter int DEV_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_valid,
  input  logic [ID_W-1:0]           wr_ident,
  input  logic [DEV_W-1:0]          wr_dev,
  input  logic [xlt_pkg::PRIV_W-1:0] wr_mask,
  input  logic [DEV_W-1:0]          wr_handle,
  output logic                      ent_valid  [ENTRIES],
  output logic [ID_W-1:0]           ent_ident  [ENTRIES],
  output logic [DEV_W-1:0]          ent_dev    [ENTRIES],
  output logic [xlt_pkg::PRIV_W-1:0] ent_mask  [ENTRIES],
  output logic [DEV_W-1:0]          ent_handle [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g]  <= 1'b0;
        ent_ident[g]  <= '0;
        ent_dev[g]    <= '0;
        ent_mask[g]   <= '0;
        ent_handle[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_valid[g]  <= wr_valid;
        ent_ident[g]  <= wr_ident;
        ent_dev[g]    <= wr_dev;
        ent_mask[g]   <= wr_mask;
        ent_handle[g] <= wr_handle;
      end
    end
  end
endmodule

// File: rtl/xlt_match.sv
module xlt_match #(
  parameter int ENTRIES = 16,
  parameter int ID_W    = 20,
  parameter int DEV_W   = 12
) (
  input  logic                       ent_valid  [ENTRIES],
  input  logic [ID_W-1:0]            ent_ident  [ENTRIES],
  input  logic [DEV_W-1:0]           ent_dev    [ENTRIES],
  input  logic [xlt_pkg::PRIV_W-1:0] ent_mask   [ENTRIES],
  input  logic [DEV_W-1:0]           ent_handle [ENTRIES],
  input  logic [ID_W-1:0]            key_ident,
  input  logic [DEV_W-1:0]           key_dev,
  input  logic [xlt_pkg::PRIV_W-1:0] key_priv,
  output logic                       hit,
  output logic [DEV_W-1:0]           handle
);
  import xlt_pkg::*;

  logic             priv_ok;
  logic [ENTRIES-1:0] ent_hit;
  logic [NUM_BUILTIN-1:0] bi_hit;

  assign priv_ok = is_onehot4(key_priv);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign ent_hit[g] = priv_ok && ent_valid[g] &&
                        (ent_ident[g] == key_ident) &&
                        (ent_dev[g] == key_dev) &&
                        ((ent_mask[g] & key_priv) != '0);
  end

  for (genvar b = 0; b < NUM_BUILTIN; b++) begin : g_bi
    assign bi_hit[b] = priv_ok && (key_dev == '0) &&
                       (key_ident == ID_W'(b + 1));
  end

  always_comb begin
    hit    = 1'b0;
    handle = '0;
    // walk downward so the lowest index is the last to assign
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_hit[i]) begin
        hit    = 1'b1;
        handle = ent_handle[i];
      end
    end
    // built-in interfaces override the table
    for (int b = 0; b < NUM_BUILTIN; b++) begin
      if (bi_hit[b]) begin
        hit    = 1'b1;
        handle = DEV_W'(b + 1);
      end
    end
  end
endmodule

// File: rtl/xlt_pack.sv
module xlt_pack #(
  parameter int XLEN  = 32,
  parameter int DEV_W = 12
) (
  input  logic             hit,
  input  logic [DEV_W-1:0] handle,
  input  logic [XLEN-1:0]  data,
  input  logic [1:0]       variant,
  output logic [XLEN-1:0]  result
);
  import xlt_pkg::*;

  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] fallback;

  assign shifted = data << DEV_W;

  always_comb begin
    unique case (variant)
      VAR_ZERO: fallback = XLEN'(1);
      VAR_MONE: fallback = XLEN'(2);
      default:  fallback = '0;
    endcase
  end

  assign result = hit ? (shifted | {{(XLEN-DEV_W){1'b0}}, handle}) : fallback;
endmodule

// File: rtl/xlt_translator.sv
module xlt_translator #(
  parameter int XLEN    = 32,
  parameter int DEV_W   = 12,
  parameter int ENTRIES = 16,
  localparam int ID_W   = XLEN - DEV_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_ident,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [3:0]        cfg_priv,
  input  logic [DEV_W-1:0]  cfg_handle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_data,
  input  logic [3:0]        req_priv,
  input  logic [1:0]        req_variant,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [XLEN-1:0]   rsp_data
);
  logic             ent_valid  [ENTRIES];
  logic [ID_W-1:0]  ent_ident  [ENTRIES];
  logic [DEV_W-1:0] ent_dev    [ENTRIES];
  logic [3:0]       ent_mask   [ENTRIES];
  logic [DEV_W-1:0] ent_handle [ENTRIES];

  logic             lk_hit;
  logic [DEV_W-1:0] lk_handle;
  logic [XLEN-1:0]  lk_result;
  logic             accept;

  xlt_table #(.ENTRIES(ENTRIES), .ID_W(ID_W), .DEV_W(DEV_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_idx),
    .wr_valid   (cfg_valid),
    .wr_ident   (cfg_ident),
    .wr_dev     (cfg_dev),
    .wr_mask    (cfg_priv),
    .wr_handle  (cfg_handle),
    .ent_valid  (ent_valid),
    .ent_ident  (ent_ident),
    .ent_dev    (ent_dev),
    .ent_mask   (ent_mask),
    .ent_handle (ent_handle)
  );

  xlt_match #(.ENTRIES(ENTRIES), .ID_W(ID_W), .DEV_W(DEV_W)) u_match (
    .ent_valid  (ent_valid),
    .ent_ident  (ent_ident),
    .ent_dev    (ent_dev),
    .ent_mask   (ent_mask),
    .ent_handle (ent_handle),
    .key_ident  (req_src[XLEN-1:DEV_W]),
    .key_dev    (req_src[DEV_W-1:0]),
    .key_priv   (req_priv),
    .hit        (lk_hit),
    .handle     (lk_handle)
  );

  xlt_pack #(.XLEN(XLEN), .DEV_W(DEV_W)) u_pack (
    .hit     (lk_hit),
    .handle  (lk_handle),
    .data    (req_data),
    .variant (req_variant),
    .result  (lk_result)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= lk_result;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlt_translator_chk.sv
module xlt_translator_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [3:0]      req_priv,
  input logic [1:0]      req_variant,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [XLEN-1:0] rsp_data
);
  logic acc;
  logic bad_priv;
  assign acc      = req_valid && req_ready;
  assign bad_priv = !xlt_pkg::is_onehot4(req_priv);

  // R9
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rsp_valid)) |-> $past(acc));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5
  bad_priv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_priv) |=> (rsp_data < XLEN'(3)));

  // R4
  rsvd_variant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_priv && req_variant == 2'd3) |=> (rsp_data == '0));
endmodule

bind xlt_translator xlt_translator_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_priv    (req_priv),
  .req_variant (req_variant),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data)
);

// File: tb/xlt_translator_tb.sv
module xlt_translator_tb;
  localparam int XLEN = 32;
  localparam int DEV_W = 12;
  localparam int ID_W = XLEN - DEV_W;
  localparam int ENTRIES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [ID_W-1:0] cfg_ident = '0;
  logic [DEV_W-1:0] cfg_dev = '0, cfg_handle = '0;
  logic [3:0] cfg_priv = '0;
  logic req_valid = 1'b0, req_ready;
  logic [XLEN-1:0] req_src = '0, req_data = '0;
  logic [3:0] req_priv = 4'b0001;
  logic [1:0] req_variant = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [XLEN-1:0] rsp_data;

  int checks = 0, errors = 0;

  // bench copy of the table contents
  logic             m_v [ENTRIES];
  logic [ID_W-1:0]  m_id [ENTRIES];
  logic [DEV_W-1:0] m_dev [ENTRIES];
  logic [3:0]       m_mask [ENTRIES];
  logic [DEV_W-1:0] m_h [ENTRIES];

  always #5 clk = ~clk;

  xlt_translator u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_ident(cfg_ident), .cfg_dev(cfg_dev),
    .cfg_priv(cfg_priv), .cfg_handle(cfg_handle), .req_valid(req_valid),
    .req_ready(req_ready), .req_src(req_src), .req_data(req_data),
    .req_priv(req_priv), .req_variant(req_variant), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  function automatic logic [XLEN-1:0] expect_rsp(input logic [ID_W-1:0] id,
      input logic [DEV_W-1:0] dev, input logic [XLEN-1:0] data,
      input logic [3:0] pv, input logic [1:0] vr);
    logic hit = 1'b0;
    logic [DEV_W-1:0] h = '0;
    logic ok = (pv == 4'b0001) || (pv == 4'b0010) || (pv == 4'b0100) || (pv == 4'b1000);
    if (ok && dev == '0 && (id == ID_W'(1) || id == ID_W'(2))) begin
      hit = 1'b1; h = DEV_W'(id);
    end else if (ok) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!hit && m_v[i] && m_id[i] == id && m_dev[i] == dev && (m_mask[i] & pv) != 0) begin
          hit = 1'b1; h = m_h[i];
        end
    end
    if (hit) return {data[XLEN-DEV_W-1:0], h};
    return (vr == 2'd1) ? XLEN'(1) : (vr == 2'd2) ? XLEN'(2) : XLEN'(0);
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic v, input logic [ID_W-1:0] id,
      input logic [DEV_W-1:0] dev, input logic [3:0] mask, input logic [DEV_W-1:0] h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v; cfg_ident = id;
    cfg_dev = dev; cfg_priv = mask; cfg_handle = h;
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[idx] = v; m_id[idx] = id; m_dev[idx] = dev; m_mask[idx] = mask; m_h[idx] = h;
  endtask

  task automatic request(input string req, input logic [ID_W-1:0] id,
      input logic [DEV_W-1:0] dev, input logic [XLEN-1:0] data,
      input logic [3:0] pv, input logic [1:0] vr);
    logic [XLEN-1:0] exp;
    @(negedge clk);
    exp = expect_rsp(id, dev, data, pv, vr);
    req_src = {id, dev}; req_data = data; req_priv = pv; req_variant = vr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R9 valid"}, XLEN'(rsp_valid), XLEN'(1));
    check(req, rsp_data, exp);
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] held, exp_b;
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_id[i] = '0; m_dev[i] = '0; m_mask[i] = '0; m_h[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", XLEN'(rsp_valid), 0);
    check("R1 req_ready", XLEN'(req_ready), 1);
    rst_n = 1'b1;
    request("R1 empty table miss", 20'h12345, 12'd0, 32'hFFFF_FFFF, 4'b0001, 2'd1);
    // R6 built-ins with empty table
    request("R6 builtin 1", 20'd1, 12'd0, 32'hFFF0_0ABC, 4'b1000, 2'd0);
    request("R6 builtin 2", 20'd2, 12'd0, 32'h0000_0001, 4'b0001, 2'd0);
    request("R6 id1 dev1 miss", 20'd1, 12'd1, 32'h1, 4'b0001, 2'd2);
    // R4 miss values
    request("R4 trap", 20'hABCDE, 12'd0, 32'h5555_5555, 4'b0010, 2'd0);
    request("R4 zero", 20'hABCDE, 12'd0, 32'h5555_5555, 4'b0010, 2'd1);
    request("R4 minus one", 20'hABCDE, 12'd0, 32'h5555_5555, 4'b0010, 2'd2);
    request("R4 reserved", 20'hABCDE, 12'd0, 32'h5555_5555, 4'b0010, 2'd3);
    // R3 R2 hit packing and field layout
    cfg_write(5, 1, 20'hABCDE, 12'd1, 4'b1111, 12'h021);
    request("R3 hit pack", 20'hABCDE, 12'd1, 32'hDEAD_BEEF, 4'b0100, 2'd0);
    request("R2 dev mismatch", 20'hABCDE, 12'd0, 32'hDEAD_BEEF, 4'b0100, 2'd1);
    request("R2 id mismatch", 20'hABCDF, 12'd1, 32'hDEAD_BEEF, 4'b0100, 2'd2);
    // R5 privilege mask
    cfg_write(6, 1, 20'h12345, 12'd0, 4'b0110, 12'h022);
    request("R5 user denied", 20'h12345, 12'd0, 32'h1, 4'b0001, 2'd1);
    request("R5 super ok", 20'h12345, 12'd0, 32'h1, 4'b0010, 2'd1);
    request("R5 not onehot", 20'h12345, 12'd0, 32'h1, 4'b0110, 2'd2);
    request("R5 zero priv builtin", 20'd1, 12'd0, 32'h1, 4'b0000, 2'd0);
    // R7 lowest index
    cfg_write(2, 1, 20'h12345, 12'd0, 4'b0010, 12'h0AA);
    request("R7 lowest wins", 20'h12345, 12'd0, 32'h7, 4'b0010, 2'd0);
    request("R7 other level", 20'h12345, 12'd0, 32'h7, 4'b0100, 2'd0);
    // R6 precedence over table
    cfg_write(0, 1, 20'd1, 12'd0, 4'b1111, 12'h777);
    request("R6 builtin precedence", 20'd1, 12'd0, 32'h9, 4'b0001, 2'd0);
    // R8 removal
    cfg_write(2, 0, 20'h12345, 12'd0, 4'b0010, 12'h0AA);
    request("R8 removed entry", 20'h12345, 12'd0, 32'h7, 4'b0010, 2'd0);
    // R8 same-edge write does not affect that request
    @(negedge clk);
    exp_b = expect_rsp(20'hBEB0B, 12'd3, 32'h3, 4'b0001, 2'd1);
    cfg_we = 1'b1; cfg_idx = 4'd9; cfg_valid = 1'b1; cfg_ident = 20'hBEB0B;
    cfg_dev = 12'd3; cfg_priv = 4'b0001; cfg_handle = 12'h0C3;
    req_src = {20'hBEB0B, 12'd3}; req_data = 32'h3; req_priv = 4'b0001;
    req_variant = 2'd1; req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    m_v[9] = 1; m_id[9] = 20'hBEB0B; m_dev[9] = 12'd3; m_mask[9] = 4'b0001; m_h[9] = 12'h0C3;
    check("R8 same edge old table", rsp_data, exp_b);
    request("R8 later edge new table", 20'hBEB0B, 12'd3, 32'h3, 4'b0001, 2'd1);
    // R11 repeat gives same answer
    request("R11 repeat a", 20'hABCDE, 12'd1, 32'h0123_4567, 4'b1000, 2'd0);
    request("R11 repeat b", 20'hABCDE, 12'd1, 32'h0123_4567, 4'b1000, 2'd0);
    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_src = {20'hABCDE, 12'd1}; req_data = 32'h0000_0FFF; req_priv = 4'b0001;
    req_variant = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    held = {20'h00FFF, 12'h021};
    check("R10 first result", rsp_data, held);
    check("R10 ready low", XLEN'(req_ready), 0);
    req_src = {20'h55555, 12'd0}; req_variant = 2'd2;
    exp_b = 32'd2;
    @(negedge clk);
    check("R10 held data", rsp_data, held);
    check("R10 still valid", XLEN'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 waiting request taken", rsp_data, exp_b);
    @(negedge clk);
    check("R10 drained", XLEN'(rsp_valid), 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [ID_W-1:0] id;
      logic [DEV_W-1:0] dev;
      logic [3:0] pv;
      int sel = $urandom_range(0, 5);
      if ($urandom_range(0, 9) == 0)
        cfg_write($urandom_range(0, 15), 1'($urandom_range(0, 3) != 0),
                  ($urandom_range(0, 1) != 0) ? 20'h12345 : 20'hABCDE,
                  12'($urandom_range(0, 2)), 4'($urandom_range(0, 15)),
                  12'($urandom_range(3, 4095)));
      id = (sel == 0) ? 20'h12345 : (sel == 1) ? 20'hABCDE : (sel == 2) ? 20'd1 :
           (sel == 3) ? 20'd2 : (sel == 4) ? 20'hBEB0B : 20'($urandom);
      dev = 12'($urandom_range(0, 3));
      pv = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'(1 << $urandom_range(0, 3));
      request("R3 R4 R5 random", id, dev, $urandom, pv, 2'($urandom_range(0, 3)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule